// File: doc/BRIEF.md
# Debug Access Lifecycle Controller

This block decides whether the external debug port and the manufacturer test mode may be used. The decision follows a device lifecycle state that can only move forward. Depending on that state, debug access is always open, always closed, or opened only after the probe answers a challenge correctly. A probe reaches the controller through a small register port. It uses that port to request lifecycle moves, to read the current challenge, to submit responses and to read status. The controller drives two enable outputs, one for the debug port and one for the test mode.

A move into the returned-for-analysis state first passes through an erase phase. In that phase the controller raises an erase request toward secret storage and keeps it high until storage acknowledges it. Debug access reopens only after the acknowledge. The response function is a keyed XOR-and-rotate placeholder that stands in for a real cryptographic primitive.

The lifecycle states, with their 3-bit codes, are:
- MANUFACTURE (0): debug and test both open.
- DEPLOYED_OPEN (1): debug open, test closed.
- DEPLOYED_AUTH (2): debug open only after a correct response, test closed.
- RETURNED (3): debug open, test closed.
- LOCKED (4): everything closed. This state is terminal.
- ERASING (5): the transient erase phase on the way to RETURNED.

The transitions are:
- a forward request from any of codes 0 to 3 to a higher code from 1 to 4;
- a request for code 3, which enters ERASING instead;
- ERASING to RETURNED when the acknowledge arrives.

Top module: `dbg_lifecycle_ctrl`

## Requirements
- R1: After reset the lifecycle code reads 0. While reset is held and in the first cycle after release, debug_en is 0. One clock after release, debug_en is 1 and test_en is 1.
- R2: A write of code c to address 0 is accepted when c is greater than the current code and c is at most 4. After the write edge, the state register (address 0, bits [2:0]) reads c, or 5 when c is 3.
- R3: A write to address 0 of a code that is not greater than the current code, or of a code above 4, is ignored. The state is unchanged and status bit 0 (bad request) is set until reset. In LOCKED every request is ignored and flagged.
- R4: In the cycle after any accepted lifecycle change, debug_en is 0. It becomes 1 one cycle later only if the new state's gating condition holds.
- R5: test_en is 1 only in MANUFACTURE, and once that state is left it never returns to 1.
- R6: In DEPLOYED_OPEN and RETURNED, debug_en is 1 without any authentication.
- R7: In DEPLOYED_AUTH, debug_en stays 0 until address 1 is written with the correct response. The correct response is rotl(chal ^ key, 7) ^ key, where chal is the value at address 1 and key is auth_key. debug_en rises one cycle after the write edge.
- R8: Every response write in DEPLOYED_AUTH, whether right or wrong, replaces the challenge with a new, different value. Response writes in other states leave the challenge unchanged.
- R9: Three consecutive wrong responses set status bit 2 (lockout). Status bits [15:8] hold the consecutive-failure count. While locked out, even a correct response is ignored and the challenge stays the same, until reset. A correct response clears the count.
- R10: A request for code 3 enters ERASING, which reads as code 5. In ERASING, erase_req is 1, debug_en is 0 and test_en is 0, and lifecycle requests are ignored without being flagged. The controller stays there until erase_ack. It then reads code 3, and debug_en is 1 one cycle after that.
- R11: In LOCKED, debug_en and test_en are 0 and response writes are ignored.
- R12: Reads are combinational: address 0 gives the state, address 1 the challenge (never 0), address 2 the status, address 3 zero. Status bit 1 shows authentication success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 lifecycle request, 1 response) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |
| auth_key | input | 32 | Authentication key from secret storage |
| erase_req | output | 1 | Secret erase request |
| erase_ack | input | 1 | Secret erase acknowledge |
| debug_en | output | 1 | Debug port enable |
| test_en | output | 1 | Manufacturer test mode enable |
| bad_req | output | 1 | Sticky flag for ignored lifecycle requests |

## Verification
The hardest condition to reach from the ports is the lockout with a correct answer pending. It needs three wrong answers in a row, each against a freshly issued challenge, followed by a response that would otherwise pass. The stimulus reads the challenge before each attempt and computes the right answer in the bench. After the lockout it submits that right answer and shows that debug stays closed and the challenge does not move. The erase wait is stretched by holding the acknowledge back for several cycles, and a lifecycle request is written during the wait.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [2:0] {
        LC_MFG   = 3'd0,
        LC_OPEN  = 3'd1,
        LC_AUTH  = 3'd2,
        LC_RET   = 3'd3,
        LC_LOCK  = 3'd4,
        LC_ERASE = 3'd5
    } lc_e;

    localparam logic [1:0] ADDR_LC   = 2'd0;
    localparam logic [1:0] ADDR_RESP = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // ordering used for forward-only movement; the erase phase ranks with RETURNED
    function automatic logic [2:0] lc_rank(input logic [2:0] code);
        return (code == 3'd5) ? 3'd3 : code;
    endfunction

endpackage

// File: rtl/dlc_lfsr.sv
module dlc_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] TAPS  = 32'h8020_0003,
    parameter logic [31:0] SEED  = 32'h1D2C_3B4A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS[WIDTH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED[WIDTH-1:0];
        end else if (step) begin
            state_q <= state_d;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/dlc_auth.sv
module dlc_auth #(
    parameter int DATA_W   = 32,
    parameter int ROT      = 7,
    parameter int MAX_FAIL = 3,
    localparam int CNT_W   = $clog2(MAX_FAIL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attempt,
    input  logic [DATA_W-1:0] response,
    input  logic [DATA_W-1:0] challenge,
    input  logic [DATA_W-1:0] key,
    input  logic              clr_ok,
    output logic              auth_ok,
    output logic [CNT_W-1:0]  fail_cnt,
    output logic              locked_out,
    output logic              step
);

    logic [DATA_W-1:0] mixed;
    logic [DATA_W-1:0] expected;
    logic              match;

    always_comb begin
        mixed    = challenge ^ key;
        expected = ((mixed << ROT) | (mixed >> (DATA_W - ROT))) ^ key;
        match    = (response == expected);
    end

    assign locked_out = (fail_cnt >= CNT_W'(MAX_FAIL));
    assign step       = attempt && !locked_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auth_ok  <= 1'b0;
            fail_cnt <= '0;
        end else if (clr_ok) begin
            auth_ok  <= 1'b0;
        end else if (step) begin
            if (match) begin
                auth_ok  <= 1'b1;
                fail_cnt <= '0;
            end else begin
                auth_ok  <= 1'b0;
                fail_cnt <= fail_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dlc_regport.sv
module dlc_regport #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [2:0]        lc_code,
    input  logic [DATA_W-1:0] challenge,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rd_data
);
    import dlc_pkg::*;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_LC)) begin
            rd_data[2:0] = lc_code;
        end else if (rd_addr == ADDR_W'(ADDR_RESP)) begin
            rd_data = challenge;
        end else if (rd_addr == ADDR_W'(ADDR_STAT)) begin
            rd_data = status;
        end
    end

endmodule

// File: rtl/dbg_lifecycle_ctrl.sv
module dbg_lifecycle_ctrl #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 2,
    parameter int          ROT      = 7,
    parameter int          MAX_FAIL = 3,
    parameter logic [31:0] SEED     = 32'h1D2C_3B4A,
    localparam int         CNT_W    = $clog2(MAX_FAIL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] auth_key,
    output logic              erase_req,
    input  logic              erase_ack,
    output logic              debug_en,
    output logic              test_en,
    output logic              bad_req
);
    import dlc_pkg::*;

    lc_e               state_q;
    lc_e               state_d;
    logic [2:0]        lc_code;
    logic              lc_change;
    logic              bad_set;
    logic              lc_req_wr;
    logic              resp_wr;
    logic [2:0]        req_code;
    logic              gate;
    logic              dbg_q;
    logic              bad_q;
    logic [DATA_W-1:0] challenge;
    logic              auth_ok;
    logic [CNT_W-1:0]  fail_cnt;
    logic              locked_out;
    logic              chal_step;
    logic [DATA_W-1:0] status;

    assign lc_req_wr = wr_en && (wr_addr == ADDR_W'(ADDR_LC));
    assign resp_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_RESP));
    assign req_code  = wr_data[2:0];
    assign lc_code   = state_q;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        lc_change = 1'b0;
        bad_set   = 1'b0;
        unique case (state_q)
            LC_MFG, LC_OPEN, LC_AUTH, LC_RET: begin
                if (lc_req_wr) begin
                    if ((req_code > lc_code) && (req_code <= 3'd4)) begin
                        lc_change = 1'b1;
                        state_d   = (req_code == 3'd3) ? LC_ERASE : lc_e'(req_code);
                    end else begin
                        bad_set = 1'b1;
                    end
                end
            end
            LC_ERASE: begin
                if (erase_ack) begin
                    lc_change = 1'b1;
                    state_d   = LC_RET;
                end
            end
            LC_LOCK: begin
                if (lc_req_wr) begin
                    bad_set = 1'b1;
                end
            end
            default: begin
                lc_change = 1'b1;
                state_d   = LC_LOCK;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LC_MFG;
        end else begin
            state_q <= state_d;
        end
    end

    // output logic
    always_comb begin
        gate      = 1'b0;
        test_en   = 1'b0;
        erase_req = 1'b0;
        unique case (state_q)
            LC_MFG: begin
                gate    = 1'b1;
                test_en = 1'b1;
            end
            LC_OPEN:  gate = 1'b1;
            LC_AUTH:  gate = auth_ok;
            LC_RET:   gate = 1'b1;
            LC_ERASE: erase_req = 1'b1;
            LC_LOCK:  gate = 1'b0;
            default:  gate = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            dbg_q <= gate && !lc_change;
            if (bad_set) begin
                bad_q <= 1'b1;
            end
        end
    end

    assign debug_en = dbg_q;
    assign bad_req  = bad_q;

    dlc_lfsr #(
        .WIDTH (DATA_W),
        .SEED  (SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (chal_step),
        .value (challenge)
    );

    dlc_auth #(
        .DATA_W   (DATA_W),
        .ROT      (ROT),
        .MAX_FAIL (MAX_FAIL)
    ) u_auth (
        .clk        (clk),
        .rst_n      (rst_n),
        .attempt    (resp_wr && (state_q == LC_AUTH)),
        .response   (wr_data),
        .challenge  (challenge),
        .key        (auth_key),
        .clr_ok     (lc_change),
        .auth_ok    (auth_ok),
        .fail_cnt   (fail_cnt),
        .locked_out (locked_out),
        .step       (chal_step)
    );

    always_comb begin
        status            = '0;
        status[0]         = bad_q;
        status[1]         = auth_ok;
        status[2]         = locked_out;
        status[8 +: CNT_W] = fail_cnt;
    end

    dlc_regport #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .rd_addr   (rd_addr),
        .lc_code   (lc_code),
        .challenge (challenge),
        .status    (status),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] lc_code,
    input logic       debug_en,
    input logic       test_en,
    input logic       erase_req,
    input logic       erase_ack,
    input logic       locked_out
);
    import dlc_pkg::*;

    AST_RANK_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        lc_rank(lc_code) >= lc_rank($past(lc_code))); // R2

    AST_LOCK_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_code == 3'd4) |=> (lc_code == 3'd4)); // R3

    AST_CHANGE_DROPS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_code != $past(lc_code)) |-> !debug_en); // R4

    AST_TEST_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_code != 3'd0) |=> !test_en); // R5

    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_ack) |=> erase_req); // R10

    AST_ERASE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (!debug_en && !test_en)); // R10

    AST_LOCKOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_out |=> locked_out); // R9

    AST_LOCKED_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_code == 3'd4) |-> (!debug_en && !test_en)); // R11

endmodule

bind dbg_lifecycle_ctrl dlc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lc_code    (lc_code),
    .debug_en   (debug_en),
    .test_en    (test_en),
    .erase_req  (erase_req),
    .erase_ack  (erase_ack),
    .locked_out (locked_out)
);

// File: tb/dbg_lifecycle_ctrl_test.sv
`timescale 1ns/1ps
module dbg_lifecycle_ctrl_test;

    localparam logic [31:0] KEY = 32'hA5C3_0F96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] auth_key = KEY;
    logic        erase_req;
    logic        erase_ack = 1'b0;
    logic        debug_en;
    logic        test_en;
    logic        bad_req;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dbg_lifecycle_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .auth_key  (auth_key),
        .erase_req (erase_req),
        .erase_ack (erase_ack),
        .debug_en  (debug_en),
        .test_en   (test_en),
        .bad_req   (bad_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] good_resp(input logic [31:0] ch);
        logic [31:0] m;
        m = ch ^ KEY;
        return {m[24:0], m[31:25]} ^ KEY;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ne(input string req, input logic [31:0] a, input logic [31:0] b);
        total = total + 1;
        if (a === b) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected a value other than %h", req, a, b);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        erase_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sc_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 debug_en in reset", {31'b0, debug_en}, 32'd0);
        rst_n = 1'b1;
        chk("R1 debug_en before first edge", {31'b0, debug_en}, 32'd0);
        rd(2'd0, d);
        chk("R1 R12 state after reset", d, 32'd0);
        @(negedge clk);
        chk("R1 debug_en after one clock", {31'b0, debug_en}, 32'd1);
        chk("R5 test_en in manufacture", {31'b0, test_en}, 32'd1);
        rd(2'd1, d);
        chk_ne("R12 challenge nonzero", d, 32'd0);
        rd(2'd3, d);
        chk("R12 unused address", d, 32'd0);
    endtask

    task automatic sc_open();
        logic [31:0] d, c0;
        do_reset();
        @(negedge clk);
        wr(2'd0, 32'd1);
        rd(2'd0, d);
        chk("R2 state open", d, 32'd1);
        chk("R4 debug drop on change", {31'b0, debug_en}, 32'd0);
        chk("R5 test off after leaving", {31'b0, test_en}, 32'd0);
        @(negedge clk);
        chk("R6 debug open in deployed-open", {31'b0, debug_en}, 32'd1);
        rd(2'd1, c0);
        wr(2'd1, good_resp(c0));
        rd(2'd1, d);
        chk("R8 challenge still outside auth", d, c0);
        chk("R3 bad flag clear before", {31'b0, bad_req}, 32'd0);
        wr(2'd0, 32'd0);
        rd(2'd0, d);
        chk("R3 backward ignored", d, 32'd1);
        rd(2'd2, d);
        chk("R3 status bad bit", d & 32'h1, 32'h1);
        chk("R3 debug unaffected", {31'b0, debug_en}, 32'd1);
        wr(2'd0, 32'd6);
        rd(2'd0, d);
        chk("R3 out-of-range code ignored", d, 32'd1);
    endtask

    task automatic sc_auth();
        logic [31:0] d, c0, c1, c2;
        do_reset();
        @(negedge clk);
        wr(2'd0, 32'd2);
        chk("R4 debug drop entering auth", {31'b0, debug_en}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 debug closed unauthenticated", {31'b0, debug_en}, 32'd0);
        rd(2'd1, c0);
        wr(2'd1, good_resp(c0) ^ 32'h1);
        rd(2'd1, c1);
        chk_ne("R8 new challenge after failure", c1, c0);
        rd(2'd2, d);
        chk("R9 fail count one", d & 32'hFF06, 32'h0100);
        @(negedge clk);
        chk("R7 wrong response keeps debug closed", {31'b0, debug_en}, 32'd0);
        wr(2'd1, good_resp(c1));
        chk("R7 debug one cycle late", {31'b0, debug_en}, 32'd0);
        @(negedge clk);
        chk("R7 debug open after correct response", {31'b0, debug_en}, 32'd1);
        rd(2'd2, d);
        chk("R9 R12 count cleared and ok bit", d & 32'hFF06, 32'h0002);
        rd(2'd1, c2);
        chk_ne("R8 new challenge after success", c2, c1);
    endtask

    task automatic sc_lockout();
        logic [31:0] d, c;
        do_reset();
        @(negedge clk);
        wr(2'd0, 32'd2);
        for (int i = 0; i < 3; i++) begin
            rd(2'd1, c);
            wr(2'd1, good_resp(c) ^ 32'h8000_0000);
        end
        rd(2'd2, d);
        chk("R9 lockout after three failures", d & 32'hFF04, 32'h0304);
        rd(2'd1, c);
        wr(2'd1, good_resp(c));
        @(negedge clk);
        chk("R9 correct response rejected in lockout", {31'b0, debug_en}, 32'd0);
        rd(2'd1, d);
        chk("R9 challenge frozen in lockout", d, c);
        wr(2'd0, 32'd4);
        rd(2'd0, d);
        chk("R2 state locked", d, 32'd4);
        wr(2'd0, 32'd3);
        rd(2'd0, d);
        chk("R3 locked is terminal", d, 32'd4);
        chk("R3 request in locked flagged", {31'b0, bad_req}, 32'd1);
    endtask

    task automatic sc_return();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        wr(2'd0, 32'd1);
        @(negedge clk);
        wr(2'd0, 32'd3);
        rd(2'd0, d);
        chk("R10 erasing code", d, 32'd5);
        chk("R10 erase_req raised", {31'b0, erase_req}, 32'd1);
        chk("R10 debug closed while erasing", {31'b0, debug_en}, 32'd0);
        wr(2'd0, 32'd4);
        repeat (4) @(negedge clk);
        rd(2'd0, d);
        chk("R10 request during erase ignored", d, 32'd5);
        chk("R10 no flag during erase", {31'b0, bad_req}, 32'd0);
        chk("R10 erase_req held", {31'b0, erase_req}, 32'd1);
        chk("R10 test closed while erasing", {31'b0, test_en}, 32'd0);
        erase_ack = 1'b1;
        @(negedge clk);
        erase_ack = 1'b0;
        rd(2'd0, d);
        chk("R10 returned after ack", d, 32'd3);
        chk("R10 erase_req dropped", {31'b0, erase_req}, 32'd0);
        chk("R4 debug low on entering returned", {31'b0, debug_en}, 32'd0);
        @(negedge clk);
        chk("R6 R10 debug open in returned", {31'b0, debug_en}, 32'd1);
    endtask

    task automatic sc_locked();
        logic [31:0] d, c;
        do_reset();
        @(negedge clk);
        wr(2'd0, 32'd4);
        repeat (3) @(negedge clk);
        chk("R11 debug closed in locked", {31'b0, debug_en}, 32'd0);
        chk("R11 R5 test closed in locked", {31'b0, test_en}, 32'd0);
        rd(2'd1, c);
        wr(2'd1, good_resp(c));
        @(negedge clk);
        chk("R11 response ignored", {31'b0, debug_en}, 32'd0);
        rd(2'd1, d);
        chk("R11 challenge unchanged", d, c);
    endtask

    initial begin
        sc_reset();
        sc_open();
        sc_auth();
        sc_lockout();
        sc_return();
        sc_locked();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule